// File: doc/BRIEF.md
# CD Sector Decode Status Controller

This block follows a stream of 2352-byte CD sectors as another agent writes them into a circular byte buffer. Each written byte comes with its position inside the sector and the buffer address it went to. The block watches for byte position 12, where the sync of the next block has just been received. At that point it marks the header and status as stale and releases the decode interrupt. If decoding is enabled, it also starts a fixed-length decode window and can capture where the finished block begins in the buffer.

When the window runs out, the block lowers an active-low decode interrupt pin and marks the status as valid with a good-CRC flag. If write request is on at that moment, it also reads four header bytes from the buffer, starting at the block pointer, into header registers. A host reaches the registers through an 8-bit port. The host first selects a register by writing an address register, and can then read it or write it. Decode-enable and write-request arrive as static control inputs. The block only reads the buffer; it never writes it.

Top module: `sector_decode_ctrl`

## Requirements
- R1: Under synchronous reset the interrupt status register (address 0) reads 0xFF and `dec_irq_n` is 1. The stale-status register (address 8) reads 0x80. The pointer registers (1, 2), header registers (3..6) and CRC status register (7) read 0x00. No buffer read is issued.
- R2: A byte with `wr_valid` high and `wr_offset` equal to 12 is a sync. On the next cycle, bit 7 of register 8 is 1 and `dec_irq_n` (bit 5 of register 0) is 1. A sync with `ctrl_dec_en` low starts no decode and changes neither the pointer nor the headers.
- R3: A sync with `ctrl_dec_en` and `ctrl_wr_req` both high loads the pointer registers with the 16-bit value `wr_addr - 2352`: low byte at address 1, high byte at address 2.
- R4: A sync with `ctrl_dec_en` high and `ctrl_wr_req` low starts a decode but leaves the pointer registers unchanged.
- R5: A decode completes exactly `2352*4*STEP_CYCLES` clock cycles after its sync edge. On completion `dec_irq_n` and bit 5 of register 0 go to 0 (register 0 reads 0xDF), register 8 reads 0x00, and register 7 reads 0x80.
- R6: If `ctrl_wr_req` is high at completion, the block reads exactly four buffer bytes at pointer+0..3, wrapping modulo 2^ADDR_W. Within 8 cycles these bytes appear in header registers 3..6, in that order.
- R7: If `ctrl_wr_req` is low at completion, no buffer read is issued and the header registers keep their values.
- R8: A host read strobe (`reg_re`) while register 8 is selected sets `dec_irq_n` back to 1 on the next cycle.
- R9: A host write to address 9 sets register 0 to 0xFF, which releases `dec_irq_n`.
- R10: Host writes to addresses 1 and 2 store the byte and read back. They never start a decode: `dec_irq_n` stays 1 and no buffer read follows.
- R11: Reading any address from 9 to 31 returns 0xFF.
- R12: A sync with `ctrl_dec_en` high while a window is already running restarts the window. Completion then follows the later sync by the full window length.
- R13: A byte with `wr_valid` high at any offset other than 12 has no effect, and neither does offset 12 with `wr_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A sector byte is being written this cycle |
| wr_offset | input | OFFS_W | Byte position of that byte inside its sector |
| wr_addr | input | ADDR_W | Buffer address of that byte |
| ctrl_dec_en | input | 1 | Decode enable |
| ctrl_wr_req | input | 1 | Write request: load pointer at sync, fetch headers at completion |
| reg_addr_we | input | 1 | Load the register address |
| reg_addr_din | input | 5 | New register address |
| reg_we | input | 1 | Write strobe to the selected register |
| reg_wdata | input | 8 | Write data |
| reg_re | input | 1 | Read strobe for the selected register (side effects only) |
| reg_rdata | output | 8 | Contents of the selected register |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rd_addr | output | ADDR_W | Buffer read address |
| buf_rd_data | input | 8 | Buffer data, one cycle after the request |
| dec_irq_n | output | 1 | Active-low decode interrupt |

## Verification
The bench samples the interrupt pin one cycle before and exactly at the end of the decode window. A counter that is off by one would fail one of those two samples. It places a block so that the header fetch crosses the top of the buffer; a fetch without wrap-around would read the wrong bytes into headers 2 and 3. It sends a second sync partway through a window, so a design that ignored the restart would raise its interrupt about 1500 cycles early. It also runs decodes with write request low, where a design that fetched anyway would show extra buffer reads and changed headers. Finally, it writes the pointer registers by hand, where a design that decoded on pointer writes would lower the interrupt.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    // Host-visible register selector
    typedef enum logic [4:0] {
        RA_IRQ      = 5'd0,
        RA_PTR_LO   = 5'd1,
        RA_PTR_HI   = 5'd2,
        RA_HDR0     = 5'd3,
        RA_HDR1     = 5'd4,
        RA_HDR2     = 5'd5,
        RA_HDR3     = 5'd6,
        RA_CRC      = 5'd7,
        RA_STALE    = 5'd8,
        RA_SOFT_RST = 5'd9
    } reg_sel_e;

    localparam int HDR_BYTES   = 4;
    localparam int IDX_W       = $clog2(HDR_BYTES);
    localparam int IRQ_DEC_BIT = 5;
    localparam int PTR_W       = 16;

    // Event produced at a sector sync boundary
    typedef struct packed {
        logic             hit;
        logic             decode;
        logic             load_ptr;
        logic [PTR_W-1:0] ptr;
    } sync_evt_t;

    // One captured header byte
    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } hdr_wr_t;

    function automatic logic [PTR_W-1:0] block_start(input logic [PTR_W-1:0] waddr,
                                                     input logic [PTR_W-1:0] span);
        return waddr - span;
    endfunction

endpackage

// File: rtl/sdc_window_timer.sv
module sdc_window_timer #(
    parameter int WINDOW = 9408,
    parameter int CNT_W  = $clog2(WINDOW + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(WINDOW - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy = busy_q;
    // A restart on the same edge pre-empts completion
    assign done = busy_q && (cnt_q == '0) && !start;

endmodule

// File: rtl/sdc_header_fetch.sv
module sdc_header_fetch
    import sdc_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [PTR_W-1:0]  base,
    input  logic [7:0]        buf_rd_data,
    output logic              buf_rd_en,
    output logic [ADDR_W-1:0] buf_rd_addr,
    output hdr_wr_t           hdr_wr
);
    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    logic [PTR_W-1:0] base_q;
    logic             cap_q;
    logic [IDX_W-1:0] cap_idx_q;
    logic [PTR_W-1:0] sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            idx_q     <= '0;
            base_q    <= '0;
            cap_q     <= 1'b0;
            cap_idx_q <= '0;
        end else begin
            cap_q     <= active_q;
            cap_idx_q <= idx_q;
            if (go && !active_q) begin
                active_q <= 1'b1;
                idx_q    <= '0;
                base_q   <= base;
            end else if (active_q) begin
                if (idx_q == IDX_W'(HDR_BYTES - 1)) begin
                    active_q <= 1'b0;
                end
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign sum         = base_q + PTR_W'(idx_q);
    assign buf_rd_en   = active_q;
    assign buf_rd_addr = sum[ADDR_W-1:0];
    assign hdr_wr      = '{we: cap_q, idx: cap_idx_q, data: buf_rd_data};

endmodule

// File: rtl/sdc_regs.sv
module sdc_regs
    import sdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  sync_evt_t        sync_evt,
    input  logic             dec_done,
    input  hdr_wr_t          hdr_wr,
    input  logic             reg_addr_we,
    input  logic [4:0]       reg_addr_din,
    input  logic             reg_we,
    input  logic [7:0]       reg_wdata,
    input  logic             reg_re,
    output logic [7:0]       reg_rdata,
    output logic [4:0]       addr_cur,
    output logic [PTR_W-1:0] ptr,
    output logic             dec_irq_n
);
    logic [4:0] addr_q;
    logic [7:0] irq_q;
    logic [7:0] ptr_lo_q;
    logic [7:0] ptr_hi_q;
    logic       crc_ok_q;
    logic       stale_q;
    logic [HDR_BYTES-1:0][7:0] hdr_flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            irq_q    <= 8'hFF;
            ptr_lo_q <= '0;
            ptr_hi_q <= '0;
            crc_ok_q <= 1'b0;
            stale_q  <= 1'b1;
        end else begin
            if (reg_addr_we) begin
                addr_q <= reg_addr_din;
            end
            if (reg_we) begin
                case (addr_q)
                    RA_PTR_LO:   ptr_lo_q <= reg_wdata;
                    RA_PTR_HI:   ptr_hi_q <= reg_wdata;
                    RA_SOFT_RST: irq_q    <= 8'hFF;
                    default:     ;
                endcase
            end
            if (reg_re && addr_q == RA_STALE) begin
                irq_q[IRQ_DEC_BIT] <= 1'b1;
            end
            // completion overrides host activity on the same edge
            if (dec_done) begin
                irq_q[IRQ_DEC_BIT] <= 1'b0;
                stale_q            <= 1'b0;
                crc_ok_q           <= 1'b1;
            end
            // a sync overrides everything
            if (sync_evt.hit) begin
                stale_q            <= 1'b1;
                irq_q[IRQ_DEC_BIT] <= 1'b1;
                if (sync_evt.load_ptr) begin
                    {ptr_hi_q, ptr_lo_q} <= sync_evt.ptr;
                end
            end
        end
    end

    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (hdr_wr.we && hdr_wr.idx == IDX_W'(g)) begin
                q <= hdr_wr.data;
            end
        end
        assign hdr_flat[g] = q;
    end

    always_comb begin
        case (addr_q)
            RA_IRQ:    reg_rdata = irq_q;
            RA_PTR_LO: reg_rdata = ptr_lo_q;
            RA_PTR_HI: reg_rdata = ptr_hi_q;
            RA_HDR0:   reg_rdata = hdr_flat[0];
            RA_HDR1:   reg_rdata = hdr_flat[1];
            RA_HDR2:   reg_rdata = hdr_flat[2];
            RA_HDR3:   reg_rdata = hdr_flat[3];
            RA_CRC:    reg_rdata = {crc_ok_q, 7'b0};
            RA_STALE:  reg_rdata = {stale_q, 7'b0};
            default:   reg_rdata = 8'hFF;
        endcase
    end

    assign addr_cur  = addr_q;
    assign ptr       = {ptr_hi_q, ptr_lo_q};
    assign dec_irq_n = irq_q[IRQ_DEC_BIT];

endmodule

// File: rtl/sector_decode_ctrl.sv
module sector_decode_ctrl
    import sdc_pkg::*;
#(
    parameter int ADDR_W         = 14,
    parameter int OFFS_W         = 12,
    parameter int SECTOR_BYTES   = 2352,
    parameter int SYNC_OFFSET    = 12,
    parameter int STEP_CYCLES    = 24,
    parameter int STEPS_PER_BYTE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [OFFS_W-1:0] wr_offset,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              ctrl_dec_en,
    input  logic              ctrl_wr_req,
    input  logic              reg_addr_we,
    input  logic [4:0]        reg_addr_din,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_re,
    output logic [7:0]        reg_rdata,
    output logic              buf_rd_en,
    output logic [ADDR_W-1:0] buf_rd_addr,
    input  logic [7:0]        buf_rd_data,
    output logic              dec_irq_n
);
    localparam int WINDOW = SECTOR_BYTES * STEPS_PER_BYTE * STEP_CYCLES;
    localparam int CNT_W  = $clog2(WINDOW + 1);

    sync_evt_t        sync_evt;
    logic             sync_hit;
    logic             dec_done;
    logic             dec_busy;
    logic             fetch_go;
    logic [PTR_W-1:0] ptr;
    logic [4:0]       reg_addr_cur;
    hdr_wr_t          hdr_wr;

    assign sync_hit = wr_valid && (wr_offset == OFFS_W'(SYNC_OFFSET));

    always_comb begin
        sync_evt.hit      = sync_hit;
        sync_evt.decode   = sync_hit && ctrl_dec_en;
        sync_evt.load_ptr = sync_hit && ctrl_dec_en && ctrl_wr_req;
        sync_evt.ptr      = block_start(PTR_W'(wr_addr), PTR_W'(SECTOR_BYTES));
    end

    sdc_window_timer #(
        .WINDOW (WINDOW),
        .CNT_W  (CNT_W)
    ) timer_i (
        .clk   (clk),
        .rst   (rst),
        .start (sync_evt.decode),
        .busy  (dec_busy),
        .done  (dec_done)
    );

    assign fetch_go = dec_done && ctrl_wr_req;

    sdc_header_fetch #(
        .ADDR_W (ADDR_W)
    ) fetch_i (
        .clk         (clk),
        .rst         (rst),
        .go          (fetch_go),
        .base        (ptr),
        .buf_rd_data (buf_rd_data),
        .buf_rd_en   (buf_rd_en),
        .buf_rd_addr (buf_rd_addr),
        .hdr_wr      (hdr_wr)
    );

    sdc_regs regs_i (
        .clk          (clk),
        .rst          (rst),
        .sync_evt     (sync_evt),
        .dec_done     (dec_done),
        .hdr_wr       (hdr_wr),
        .reg_addr_we  (reg_addr_we),
        .reg_addr_din (reg_addr_din),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_re       (reg_re),
        .reg_rdata    (reg_rdata),
        .addr_cur     (reg_addr_cur),
        .ptr          (ptr),
        .dec_irq_n    (dec_irq_n)
    );

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker (
    input logic       clk,
    input logic       rst,
    input logic       sync_hit,
    input logic       dec_done,
    input logic       ctrl_wr_req,
    input logic       dec_irq_n,
    input logic       buf_rd_en,
    input logic       reg_re,
    input logic [4:0] reg_addr_cur,
    input logic [7:0] reg_rdata
);
    // R2
    sync_releases_irq_chk: assert property (@(posedge clk) disable iff (rst)
        sync_hit |=> dec_irq_n);

    // R5
    done_lowers_irq_chk: assert property (@(posedge clk) disable iff (rst)
        dec_done |=> !dec_irq_n);

    // R5
    irq_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dec_irq_n) |-> $past(dec_done));

    // R7
    fetch_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_rd_en) |-> $past(dec_done && ctrl_wr_req));

    // R8
    stale_read_release_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_re && reg_addr_cur == 5'd8 && !dec_done) |=> dec_irq_n);

    // R11
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_cur >= 5'd9) |-> (reg_rdata == 8'hFF));

endmodule

bind sector_decode_ctrl sdc_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .sync_hit     (sync_hit),
    .dec_done     (dec_done),
    .ctrl_wr_req  (ctrl_wr_req),
    .dec_irq_n    (dec_irq_n),
    .buf_rd_en    (buf_rd_en),
    .reg_re       (reg_re),
    .reg_addr_cur (reg_addr_cur),
    .reg_rdata    (reg_rdata)
);

// File: tb/sector_decode_ctrl_tb_top.sv
module sector_decode_ctrl_tb_top;
    localparam int ADDR_W = 14;
    localparam int OFFS_W = 12;
    localparam int SECTOR = 2352;
    localparam int STEP   = 1;
    localparam int SPB    = 4;
    localparam int W      = SECTOR * SPB * STEP;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_valid = 1'b0;
    logic [OFFS_W-1:0] wr_offset = '0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic              ctrl_dec_en = 1'b0;
    logic              ctrl_wr_req = 1'b0;
    logic              reg_addr_we = 1'b0;
    logic [4:0]        reg_addr_din = '0;
    logic              reg_we = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic              reg_re = 1'b0;
    logic [7:0]        reg_rdata;
    logic              buf_rd_en;
    logic [ADDR_W-1:0] buf_rd_addr;
    logic [7:0]        buf_rd_data = '0;
    logic              dec_irq_n;

    int         checks = 0;
    int         errors = 0;
    int         rd_count = 0;
    bit         finished = 0;
    logic [7:0] salt = 8'h00;
    logic [7:0] exp_hdr [4];
    logic [15:0] exp_ptr;

    always #4 clk = ~clk;

    sector_decode_ctrl #(
        .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .SECTOR_BYTES(SECTOR),
        .SYNC_OFFSET(12), .STEP_CYCLES(STEP), .STEPS_PER_BYTE(SPB)
    ) dut_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_offset(wr_offset),
        .wr_addr(wr_addr), .ctrl_dec_en(ctrl_dec_en), .ctrl_wr_req(ctrl_wr_req),
        .reg_addr_we(reg_addr_we), .reg_addr_din(reg_addr_din), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
        .dec_irq_n(dec_irq_n)
    );

    // Buffer contents are a function of address and a per-run salt
    function automatic logic [7:0] buf_byte(input logic [ADDR_W-1:0] a, input logic [7:0] s);
        int v;
        v = int'(a);
        return 8'((v * 37) + (v >> 7)) ^ s;
    endfunction

    always @(posedge clk) begin
        buf_rd_data <= buf_rd_en ? buf_byte(buf_rd_addr, salt) : 8'h00;
        if (!rst && buf_rd_en) rd_count <= rd_count + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] d);
        reg_addr_we  = 1'b1;
        reg_addr_din = a;
        tick(1);
        reg_addr_we  = 1'b0;
        d = reg_rdata;
    endtask

    task automatic check_reg(input string req, input logic [4:0] a, input int exp);
        logic [7:0] d;
        peek(a, d);
        check(req, int'(d), exp);
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [7:0] d);
        peek(a, d);
        reg_re = 1'b1;
        tick(1);
        reg_re = 1'b0;
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [7:0] d);
        reg_addr_we  = 1'b1;
        reg_addr_din = a;
        tick(1);
        reg_addr_we  = 1'b0;
        reg_we       = 1'b1;
        reg_wdata    = d;
        tick(1);
        reg_we       = 1'b0;
    endtask

    task automatic send_byte(input logic [OFFS_W-1:0] off, input logic [ADDR_W-1:0] a,
                             input bit vld, input bit en, input bit wrq);
        wr_valid    = vld;
        wr_offset   = off;
        wr_addr     = a;
        ctrl_dec_en = en;
        ctrl_wr_req = wrq;
        tick(1);
        wr_valid    = 1'b0;
        wr_offset   = 12'd100;
    endtask

    task automatic check_ptr(input string req);
        check_reg(req, 5'd1, int'(exp_ptr[7:0]));
        check_reg(req, 5'd2, int'(exp_ptr[15:8]));
    endtask

    task automatic check_hdrs(input string req);
        for (int i = 0; i < 4; i++) check_reg(req, 5'(3 + i), int'(exp_hdr[i]));
    endtask

    // One sync followed by its window and the resulting register state
    task automatic decode_round(input logic [ADDR_W-1:0] a, input bit en, input bit wrq,
                                input string ttag);
        int rc0;
        rc0 = rd_count;
        send_byte(12'd12, a, 1'b1, en, wrq);
        check("R2", int'(dec_irq_n), 1);
        if (en) begin
            if (wrq) exp_ptr = 16'(a) - 16'(SECTOR);
            tick(W - 1);
            check(ttag, int'(dec_irq_n), 1);   // one cycle before completion
            tick(1);
            check(ttag, int'(dec_irq_n), 0);   // completion edge
            tick(8);
            check_reg("R5", 5'd8, 8'h00);
            check_reg("R5", 5'd7, 8'h80);
            check_reg("R5", 5'd0, 8'hDF);
            if (wrq) begin
                check_ptr("R3");
                for (int i = 0; i < 4; i++)
                    exp_hdr[i] = buf_byte(ADDR_W'(exp_ptr + 16'(i)), salt);
                check("R6", rd_count - rc0, 4);
                check_hdrs("R6");
            end else begin
                check_ptr("R4");
                check("R7", rd_count - rc0, 0);
                check_hdrs("R7");
            end
        end else begin
            tick(W + 10);
            check("R2", int'(dec_irq_n), 1);
            check_reg("R2", 5'd8, 8'h80);
            check_ptr("R2");
            check("R2", rd_count - rc0, 0);
            check_hdrs("R2");
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4; i++) exp_hdr[i] = 8'h00;
        exp_ptr = 16'h0000;
        tick(5);
        check("R1", int'(dec_irq_n), 1);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        check("R1", int'(dec_irq_n), 1);
        check_reg("R1", 5'd0, 8'hFF);
        check_reg("R1", 5'd8, 8'h80);
        check_reg("R1", 5'd7, 8'h00);
        check_ptr("R1");
        check_hdrs("R1");
        check("R1", rd_count, 0);

        // R11 unmapped reads
        check_reg("R11", 5'd9, 8'hFF);
        check_reg("R11", 5'd15, 8'hFF);
        check_reg("R11", 5'd31, 8'hFF);

        // R10 pointer writes store only; R13 non-sync bytes ignored
        reg_write(5'd1, 8'h5A);
        reg_write(5'd2, 8'h13);
        exp_ptr = 16'h135A;
        check_ptr("R10");
        send_byte(12'd11, 14'd3000, 1'b1, 1'b1, 1'b1);
        send_byte(12'd13, 14'd3000, 1'b1, 1'b1, 1'b1);
        send_byte(12'd12, 14'd3000, 1'b0, 1'b1, 1'b1);
        tick(W + 20);
        check("R10", int'(dec_irq_n), 1);
        check("R10", rd_count, 0);
        check_ptr("R13");
        check_reg("R13", 5'd7, 8'h00);

        // Full decode with header fetch: 100 - 2352 = 0xF734
        salt = 8'($urandom);
        decode_round(14'd100, 1'b1, 1'b1, "R5");

        // Sync without decode enable releases interrupt only (R2)
        decode_round(14'd7000, 1'b0, 1'b1, "R2");

        // Decode enable without write request (R4, R7)
        salt = 8'($urandom);
        decode_round(14'd5000, 1'b1, 1'b0, "R5");

        // R8 stale-status read releases interrupt
        check("R8", int'(dec_irq_n), 0);
        reg_read(5'd8, d);
        check("R8", int'(d), 8'h00);
        check("R8", int'(dec_irq_n), 1);
        check_reg("R8", 5'd0, 8'hFF);

        // Fetch crossing the buffer top: 2350 - 2352 -> 0x3FFE, 0x3FFF, 0x0000, 0x0001 (R6)
        salt = 8'($urandom);
        decode_round(14'd2350, 1'b1, 1'b1, "R5");

        // R9 soft reset register
        check("R9", int'(dec_irq_n), 0);
        reg_write(5'd9, 8'h00);
        check("R9", int'(dec_irq_n), 1);
        check_reg("R9", 5'd0, 8'hFF);

        // R12 restart inside a running window
        send_byte(12'd12, 14'd9000, 1'b1, 1'b1, 1'b1);
        tick(1500);
        check("R12", int'(dec_irq_n), 1);
        salt = 8'($urandom);
        decode_round(14'd12000, 1'b1, 1'b1, "R12");

        // Random rounds
        for (int r = 0; r < 5; r++) begin
            logic [ADDR_W-1:0] a;
            bit en;
            bit wrq;
            a    = ADDR_W'($urandom);
            en   = ($urandom % 4) != 0;
            wrq  = 1'($urandom);
            salt = 8'($urandom);
            decode_round(a, en, wrq, "R5");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule